// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Unit

This block is a packed SIMD arithmetic stage for signed fixed-point data. Each lane multiplies two signed elements, doubles the product, and adds it to or subtracts it from an accumulator element taken from the same lane. The result is then rounded to the upper half of the doubled-width value and clamped to the lane range. The result replaces the accumulator element, so the output vector is meant to be written back over the accumulator register that fed the block.

The vector is 128 bits wide. It is split into eight 16-bit lanes or four 32-bit lanes, chosen per operation. An active length in bytes sets how much of the vector is computed. Every 64-bit chunk beyond that length is written as zero. A sticky flag records that some active lane was clamped, and it stays set until software clears it.

Operands enter through a valid/ready input and leave through a valid/ready output, with one register stage between them. The input is ready whenever the output register is empty or is being drained in the same cycle. If the output is stalled, the stored result holds steady and no new operation is taken. The flag and its clear input are plain level signals.

Top module: `sqrdm_mac`

## Requirements
- R1: With `in_wide`=0 (16-bit lanes), each lane's result is floor((acc·2^15 + a·b + 2^14) / 2^15), where a, b and acc are the lane's signed 16-bit operands. The value is then clamped as in R3.
- R2: With `in_wide`=1 (32-bit lanes), each lane's result is floor((acc·2^31 + a·b + 2^30) / 2^31), computed without loss of precision. The value is then clamped as in R3.
- R3: A result above the lane's signed maximum becomes 0x7FFF (16-bit) or 0x7FFFFFFF (32-bit). A result below the minimum becomes 0x8000 or 0x80000000. The case a = b = most negative value with acc = 0 clamps to the maximum in both lane widths.
- R4: With `in_sub`=1, the product a·b is subtracted instead of added. Rounding, shift and clamping are the same as for addition.
- R5: A 16-bit lane i occupies bits 16i+15:16i and a 32-bit lane j occupies bits 32j+31:32j of every vector port. Lanes are computed independently.
- R6: The 64-bit chunk c of `out_res` (bits 64c+63:64c) is zero when `in_act_bytes` < 8(c+1). Clamping in such a chunk does not set the flag.
- R7: `sat_flag` is set by an accepted operation in which any active lane clamps. It then stays set until `sat_clr` is high for a cycle with no such operation. If a clamp and a clear occur together, the flag ends up set.
- R8: An input accepted at a clock edge (`in_valid` and `in_ready` both high) shows its result with `out_valid` high right after that edge. `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_res` holds.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_res` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand vectors and controls are valid |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_op_a | input | 128 | First multiplicand vector |
| in_op_b | input | 128 | Second multiplicand vector |
| in_acc | input | 128 | Accumulator vector (the destination's old value) |
| in_sub | input | 1 | 0 adds the product, 1 subtracts it |
| in_wide | input | 1 | 0 selects 16-bit lanes, 1 selects 32-bit lanes |
| in_act_bytes | input | 5 | Active length in bytes (8 or 16) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 128 | Result vector |
| sat_flag | output | 1 | Sticky clamp indicator |
| sat_clr | input | 1 | Clears the sticky clamp indicator |

## Verification
Each result and its effect on the flag are due at the first clock edge after the input was accepted. The bench drives on the falling edge, keeps `out_ready` high, and reads `out_res`, `out_valid` and `sat_flag` on the next falling edge. In the stall test, it reads the held result on each stalled falling edge, then reads the second result on the falling edge after the stall is released. A clear pulsed without an input is checked one falling edge later.

// File: rtl/sqrdm_pkg.sv
package sqrdm_pkg;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int CHUNK_W  = 64;
  localparam int PER_SLOT = WIDE_W / NARROW_W;

  typedef enum logic {
    LANES_16 = 1'b0,
    LANES_32 = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/sqrdm_elem.sv
module sqrdm_elem #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] acc,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int PW = 2 * W + 2;
  localparam int SH = W - 1;
  localparam logic signed [PW-1:0] RND = PW'(1) << (W - 2);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] a_x, b_x, acc_x, prod, sum, shifted;
  logic [PW-SH-1:0]     upper;
  logic                 fits;

  always_comb begin
    a_x     = {{(PW-W){op_a[W-1]}}, op_a};
    b_x     = {{(PW-W){op_b[W-1]}}, op_b};
    acc_x   = {{(PW-W){acc[W-1]}}, acc};
    prod    = a_x * b_x;
    sum     = (acc_x <<< SH) + (sub ? -prod : prod) + RND;
    shifted = sum >>> SH;
    upper   = shifted[PW-1:SH];
    fits    = (&upper) | ~(|upper);
    sat     = ~fits;
    if (fits)             res = shifted[W-1:0];
    else if (upper[PW-SH-1]) res = NEG_MIN;
    else                  res = POS_MAX;
  end
endmodule

// File: rtl/sqrdm_slot.sv
module sqrdm_slot
  import sqrdm_pkg::*;
(
  input  logic [WIDE_W-1:0] op_a,
  input  logic [WIDE_W-1:0] op_b,
  input  logic [WIDE_W-1:0] acc,
  input  logic              sub,
  input  lane_mode_e        mode,
  output logic [WIDE_W-1:0] res,
  output logic              sat
);
  logic [WIDE_W-1:0]   narrow_res;
  logic [PER_SLOT-1:0] narrow_sat;
  logic [WIDE_W-1:0]   wide_res;
  logic                wide_sat;

  for (genvar h = 0; h < PER_SLOT; h++) begin : g_narrow
    sqrdm_elem #(.W(NARROW_W)) u_elem (
      .op_a (op_a[h*NARROW_W +: NARROW_W]),
      .op_b (op_b[h*NARROW_W +: NARROW_W]),
      .acc  (acc[h*NARROW_W +: NARROW_W]),
      .sub  (sub),
      .res  (narrow_res[h*NARROW_W +: NARROW_W]),
      .sat  (narrow_sat[h])
    );
  end

  sqrdm_elem #(.W(WIDE_W)) u_wide (
    .op_a (op_a),
    .op_b (op_b),
    .acc  (acc),
    .sub  (sub),
    .res  (wide_res),
    .sat  (wide_sat)
  );

  always_comb begin
    if (mode == LANES_32) begin
      res = wide_res;
      sat = wide_sat;
    end else begin
      res = narrow_res;
      sat = |narrow_sat;
    end
  end
endmodule

// File: rtl/sqrdm_mac.sv
module sqrdm_mac
  import sqrdm_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int LEN_W = $clog2(VEC_W / 8 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_op_a,
  input  logic [VEC_W-1:0] in_op_b,
  input  logic [VEC_W-1:0] in_acc,
  input  logic             in_sub,
  input  logic             in_wide,
  input  logic [LEN_W-1:0] in_act_bytes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_res,
  output logic             sat_flag,
  input  logic             sat_clr
);
  localparam int NSLOT      = VEC_W / WIDE_W;
  localparam int CHUNK_BYTE = CHUNK_W / 8;

  lane_mode_e       mode;
  logic [VEC_W-1:0] nxt_res;
  logic [NSLOT-1:0] slot_sat;
  logic             fire;

  assign mode = lane_mode_e'(in_wide);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int CHUNK = (s * WIDE_W) / CHUNK_W;
    logic [WIDE_W-1:0] r;
    logic              st;
    logic              live;

    sqrdm_slot u_slot (
      .op_a (in_op_a[s*WIDE_W +: WIDE_W]),
      .op_b (in_op_b[s*WIDE_W +: WIDE_W]),
      .acc  (in_acc[s*WIDE_W +: WIDE_W]),
      .sub  (in_sub),
      .mode (mode),
      .res  (r),
      .sat  (st)
    );

    assign live = in_act_bytes >= LEN_W'((CHUNK + 1) * CHUNK_BYTE);
    assign nxt_res[s*WIDE_W +: WIDE_W] = live ? r : '0;
    assign slot_sat[s] = live & st;
  end

  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (fire)     out_res   <= nxt_res;
      sat_flag <= (sat_flag & ~sat_clr) | (fire & (|slot_sat));
    end
  end
endmodule

// File: rtl/sqrdm_mac_chk.sv
module sqrdm_mac_chk #(
  parameter int VEC_W = 128,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LEN_W-1:0] in_act_bytes,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_res,
  input logic             sat_flag,
  input logic             sat_clr
);
  localparam int CHUNK_W = 64;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !sat_flag)); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !in_valid) |=> !sat_flag); // R7

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_act_bytes < LEN_W'(VEC_W / 8)))
      |=> (out_res[VEC_W-1:VEC_W-CHUNK_W] == '0)); // R6
endmodule

bind sqrdm_mac sqrdm_mac_chk #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_act_bytes (in_act_bytes),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_res      (out_res),
  .sat_flag     (sat_flag),
  .sat_clr      (sat_clr)
);

// File: tb/sqrdm_mac_bench.sv
`timescale 1ns/1ps
module sqrdm_mac_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_op_a = '0, in_op_b = '0, in_acc = '0;
  logic         in_sub = 1'b0, in_wide = 1'b0;
  logic [4:0]   in_act_bytes = 5'd16;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_res;
  logic         sat_flag;
  logic         sat_clr = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit flag_exp = 1'b0;

  always #2.5 clk = ~clk;

  sqrdm_mac u_sqrdm_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op_a(in_op_a), .in_op_b(in_op_b), .in_acc(in_acc),
    .in_sub(in_sub), .in_wide(in_wide), .in_act_bytes(in_act_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .sat_flag(sat_flag), .sat_clr(sat_clr)
  );

  logic [15:0] E16 [9] = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001,
                           16'h0002, 16'h4000, 16'h7FFE, 16'h7FFF};
  logic [31:0] E32 [8] = '{32'h80000000, 32'h80000001, 32'hFFFFFFFF, 32'h00000000,
                           32'h00000001, 32'h40000000, 32'h7FFFFFFE, 32'h7FFFFFFF};

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic longint ref_elem(longint a, longint b, longint c, int w, bit sub,
                                      output bit sat);
    longint p, s, sh, mx, mn;
    p = a * b;
    if (sub) p = -p;
    s  = (c <<< (w - 1)) + p + (longint'(1) <<< (w - 2));
    sh = s >>> (w - 1);
    mx = (longint'(1) <<< (w - 1)) - 1;
    mn = -mx - 1;
    sat = 1'b0;
    if (sh > mx) begin sat = 1'b1; sh = mx; end
    else if (sh < mn) begin sat = 1'b1; sh = mn; end
    return sh;
  endfunction

  function automatic logic [127:0] ref_vec(logic [127:0] a, logic [127:0] b, logic [127:0] c,
                                           bit sub, bit wide, int act, output bit any);
    logic [127:0] r = '0;
    any = 1'b0;
    if (wide) begin
      for (int i = 0; i < 4; i++) begin
        bit s;
        longint v;
        v = ref_elem(longint'($signed(a[i*32 +: 32])), longint'($signed(b[i*32 +: 32])),
                     longint'($signed(c[i*32 +: 32])), 32, sub, s);
        if (i * 4 < act) begin r[i*32 +: 32] = v[31:0]; any |= s; end
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit s;
        longint v;
        v = ref_elem(longint'($signed(a[i*16 +: 16])), longint'($signed(b[i*16 +: 16])),
                     longint'($signed(c[i*16 +: 16])), 16, sub, s);
        if (i * 2 < act) begin r[i*16 +: 16] = v[15:0]; any |= s; end
      end
    end
    return r;
  endfunction

  // one accepted operation; result and flag read one falling edge later
  task automatic run_vec(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] c, input bit sub, input bit wide,
                         input int act, input bit clr);
    logic [127:0] exp;
    bit any;
    exp = ref_vec(a, b, c, sub, wide, act, any);
    @(negedge clk);
    in_op_a = a; in_op_b = b; in_acc = c; in_sub = sub; in_wide = wide;
    in_act_bytes = 5'(act); in_valid = 1'b1; sat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    flag_exp = (clr ? 1'b0 : flag_exp) | any;
    chk({req, " valid"}, 128'(out_valid), 128'(1));
    chk({req, " result"}, out_res, exp);
    chk({req, " flag"}, 128'(sat_flag), 128'(flag_exp));
  endtask

  task automatic sweep16(input bit sub);
    for (int v = 0; v < 92; v++) begin
      logic [127:0] a, b, c;
      for (int l = 0; l < 8; l++) begin
        int k;
        k = (v * 8 + l) % 729;
        a[l*16 +: 16] = E16[k % 9];
        b[l*16 +: 16] = E16[(k / 9) % 9];
        c[l*16 +: 16] = E16[k / 81];
      end
      run_vec(sub ? "R4 R1 R3 sweep16" : "R1 R3 sweep16", a, b, c, sub, 1'b0, 16, 1'b1);
    end
  endtask

  task automatic sweep32(input bit sub);
    for (int v = 0; v < 128; v++) begin
      logic [127:0] a, b, c;
      for (int l = 0; l < 4; l++) begin
        int k;
        k = v * 4 + l;
        a[l*32 +: 32] = E32[k % 8];
        b[l*32 +: 32] = E32[(k / 8) % 8];
        c[l*32 +: 32] = E32[k / 64];
      end
      run_vec(sub ? "R4 R2 R3 sweep32" : "R2 R3 sweep32", a, b, c, sub, 1'b1, 16, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] va, vb, lane_acc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", 128'(out_valid), 128'(0));
    chk("R9 out_res", out_res, 128'(0));
    chk("R9 sat_flag", 128'(sat_flag), 128'(0));
    chk("R8 in_ready idle", 128'(in_ready), 128'(1));

    // R5 packing: zero product returns acc lane by lane
    for (int i = 0; i < 8; i++) lane_acc[i*16 +: 16] = 16'(i * 300 - 900);
    run_vec("R5 lanes16", '0, '0, lane_acc, 1'b0, 1'b0, 16, 1'b0);
    chk("R5 lanes16 equals acc", out_res, lane_acc);
    run_vec("R5 lanes32", '0, '0, lane_acc, 1'b0, 1'b1, 16, 1'b0);
    chk("R5 lanes32 equals acc", out_res, lane_acc);

    // R3 extreme corner, both widths
    run_vec("R3 corner16", {8{16'h8000}}, {8{16'h8000}}, '0, 1'b0, 1'b0, 16, 1'b1);
    chk("R3 corner16 max", out_res, {8{16'h7FFF}});
    chk("R3 corner16 flag", 128'(sat_flag), 128'(1));
    run_vec("R3 corner32", {4{32'h80000000}}, {4{32'h80000000}}, '0, 1'b0, 1'b1, 16, 1'b1);
    chk("R3 corner32 max", out_res, {4{32'h7FFFFFFF}});
    chk("R3 corner32 flag", 128'(sat_flag), 128'(1));

    // R7 sticky, clear, clear with simultaneous clamp
    run_vec("R7 sticky", '0, '0, '0, 1'b0, 1'b0, 16, 1'b0);
    chk("R7 stays set", 128'(sat_flag), 128'(1));
    @(negedge clk) sat_clr = 1'b1;
    @(negedge clk) sat_clr = 1'b0;
    flag_exp = 1'b0;
    chk("R7 cleared", 128'(sat_flag), 128'(0));
    run_vec("R7 set wins", {8{16'h8000}}, {8{16'h8000}}, '0, 1'b0, 1'b0, 16, 1'b1);
    chk("R7 set wins flag", 128'(sat_flag), 128'(1));

    // R6 tail: clamping only in the inactive chunk
    run_vec("R6 tail16", {{4{16'h8000}}, 64'h0}, {{4{16'h8000}}, 64'h0}, lane_acc,
            1'b0, 1'b0, 8, 1'b1);
    chk("R6 tail16 upper", 128'(out_res[127:64]), 128'(0));
    chk("R6 tail16 no flag", 128'(sat_flag), 128'(0));
    run_vec("R6 tail32", {{2{32'h80000000}}, 64'h0}, {{2{32'h80000000}}, 64'h0}, lane_acc,
            1'b1, 1'b1, 8, 1'b1);
    chk("R6 tail32 upper", 128'(out_res[127:64]), 128'(0));

    // exhaustive corner-value sweeps
    sweep16(1'b0); sweep16(1'b1);
    sweep32(1'b0); sweep32(1'b1);

    // random operands
    for (int n = 0; n < 300; n++) begin
      logic [127:0] a, b, c;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      c = {$urandom, $urandom, $urandom, $urandom};
      run_vec("R1 R2 R4 random", a, b, c, 1'($urandom), 1'(n % 2), (n % 3 == 0) ? 8 : 16, 1'b1);
    end

    // R8 back-pressure: two operations, output stalled
    va = {8{16'h1234}};
    vb = {8{16'h0F0F}};
    @(negedge clk);
    out_ready = 1'b0;
    in_op_a = '0; in_op_b = '0; in_acc = va; in_wide = 1'b0; in_sub = 1'b0;
    in_act_bytes = 5'd16; in_valid = 1'b1;
    @(negedge clk);
    in_acc = vb;
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall valid", 128'(out_valid), 128'(1));
      chk("R8 stall ready low", 128'(in_ready), 128'(0));
      chk("R8 stall hold", out_res, va);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second valid", 128'(out_valid), 128'(1));
    chk("R8 second result", out_res, vb);
    @(negedge clk);
    chk("R8 drained", 128'(out_valid), 128'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule